// File: doc/BRIEF.md
# Source Pixel Aligner and Expander

This block sits between the source-word supply of a 2-D drawing engine and its destination write path. Source words arrive over a valid/ready input; they may come from a memory fetch or from host writes to a source data register. Once accepted, both kinds are handled the same way. The block emits one source pixel per output handshake, always 32 bits wide.

In color mode it takes pixels from the byte lanes of the held word, lowest lane first, at 8, 16 or 32 bits per pixel. In monochrome mode each bit becomes the foreground color (bit set) or the background color (bit clear). Bytes are taken in order from byte 0 to byte 3, and within each byte from bit 7 down to bit 0. In vector mode the input stream is ignored and the foreground color is driven continuously.

A programmed line length ends each line. A start offset drops the leading pixels of the first word of each line, so that output pixel 0 lines up with the first destination pixel. Configuration inputs must stay steady while a line is in progress.

Top module: `src_pixel_aligner`

## Requirements
- R1: After reset `pix_valid_o` is 0 and, outside vector mode, `word_ready_o` is 1.
- R2: With `mode_i`=00 (color) and `depth_i`=00 (8 bpp), pixel k of a word (k=0..3) is byte k, meaning bits 8k+7:8k, zero-extended. Byte 0 is emitted first.
- R3: With `mode_i`=00 and `depth_i`=01 (16 bpp), pixel k (k=0..1) is bits 16k+15:16k, zero-extended. With `depth_i`=10 or 11 (32 bpp), the single pixel is the whole word.
- R4: With `mode_i`=01 (monochrome), a word gives 32 pixels. Pixel i tests bit 8*(i/8)+7-(i%8) and yields `fg_color_i` when that bit is 1 and `bg_color_i` when it is 0.
- R5: With `mode_i`=10 (vector), `word_ready_o` is 0, `pix_valid_o` is 1 and `pix_data_o` equals `fg_color_i`. Any word offered meanwhile is left unconsumed.
- R6: At most one word is held. A new word is accepted only after the last pixel of the held word has been emitted or the line has ended.
- R7: Once `line_len_i` pixels of a line have been emitted, the rest of the held word is dropped. The next word accepted starts a new line.
- R8: The first word of each line starts at pixel index `start_off_i` modulo the pixels per word. Later words of the line start at index 0.
- R9: While `pix_valid_o` is 1 and `pix_ready_i` is 0 (not vector mode), the next cycle keeps `pix_valid_o` at 1 and `pix_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 color, 01 monochrome, 10 vector, 11 color |
| depth_i | input | 2 | 00 8 bpp, 01 16 bpp, 10/11 32 bpp |
| line_len_i | input | LINE_W | Pixels per line (nonzero) |
| start_off_i | input | IDX_W | Leading pixels dropped from the first word of a line |
| fg_color_i | input | WORD_W | Foreground color |
| bg_color_i | input | WORD_W | Background color |
| word_valid_i | input | 1 | Source word offered |
| word_data_i | input | WORD_W | Source word |
| word_ready_o | output | 1 | Source word accepted when valid |
| pix_valid_o | output | 1 | Pixel available |
| pix_data_o | output | WORD_W | Aligned or expanded pixel |
| pix_ready_i | input | 1 | Downstream takes the pixel |

## Verification
The bench builds the block with its defaults: 32-bit words, which give 1, 2, 4 or 32 pixels per word, and a 12-bit line count. These values allow lines that start mid-word, lines that span a word boundary in monochrome (40 pixels from offset 3), and lines shorter than one word that force the rest of the word to be dropped. Output backpressure comes from a fixed repeating ready pattern, so held-pixel stability and the one-word limit are exercised at every depth.

// File: rtl/spa_pkg.sv
package spa_pkg;
  typedef enum logic [1:0] {
    SM_COLOR  = 2'd0,
    SM_MONO   = 2'd1,
    SM_VECTOR = 2'd2,
    SM_COLOR2 = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    PD_8   = 2'd0,
    PD_16  = 2'd1,
    PD_32  = 2'd2,
    PD_32B = 2'd3
  } pix_depth_e;
endpackage

// File: rtl/spa_lane_sel.sv
module spa_lane_sel
  import spa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  pix_depth_e        depth_i,
  output logic [WORD_W-1:0] pix_o,
  output logic              mono_bit_o
);
  localparam int N8  = WORD_W / 8;
  localparam int N16 = WORD_W / 16;
  localparam int B_W = $clog2(N8);
  localparam int H_W = (N16 > 1) ? $clog2(N16) : 1;

  logic [7:0]  b8  [N8];
  logic [15:0] h16 [N16];

  for (genvar g = 0; g < N8; g++) begin : g_b8
    assign b8[g] = word_i[g*8 +: 8];
  end
  for (genvar g = 0; g < N16; g++) begin : g_h16
    assign h16[g] = word_i[g*16 +: 16];
  end

  // msb-first within each byte, bytes low to high
  assign mono_bit_o = word_i[idx_i ^ IDX_W'(7)];

  always_comb begin
    case (depth_i)
      PD_8:    pix_o = WORD_W'(b8[idx_i[B_W-1:0]]);
      PD_16:   pix_o = WORD_W'(h16[idx_i[H_W-1:0]]);
      default: pix_o = word_i;
    endcase
  end
endmodule

// File: rtl/spa_seq.sv
module spa_seq
  import spa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LINE_W = 12,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_mode_e         mode_i,
  input  pix_depth_e        depth_i,
  input  logic [LINE_W-1:0] line_len_i,
  input  logic [IDX_W-1:0]  start_off_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic              pix_ready_i,
  output logic              word_ready_o,
  output logic              hold_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [IDX_W:0]    ppw;
  logic [IDX_W-1:0]  last_idx, idx_q;
  logic [LINE_W-1:0] cnt_q, cnt_inc;
  logic [WORD_W-1:0] word_q;
  logic full_q, first_q, vec, accept, fire, line_end, word_end;

  always_comb begin
    if (mode_i == SM_MONO) ppw = (IDX_W+1)'(WORD_W);
    else begin
      case (depth_i)
        PD_8:    ppw = (IDX_W+1)'(WORD_W / 8);
        PD_16:   ppw = (IDX_W+1)'(WORD_W / 16);
        default: ppw = (IDX_W+1)'(1);
      endcase
    end
  end

  assign last_idx     = IDX_W'(ppw - 1'b1);
  assign vec          = (mode_i == SM_VECTOR);
  assign word_ready_o = !full_q && !vec;
  assign accept       = word_valid_i && word_ready_o;
  assign fire         = full_q && pix_ready_i && !vec;
  assign cnt_inc      = cnt_q + 1'b1;
  assign line_end     = (cnt_inc == line_len_i);
  assign word_end     = (idx_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q  <= 1'b0;
      first_q <= 1'b1;
      idx_q   <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
    end else if (accept) begin
      word_q  <= word_data_i;
      full_q  <= 1'b1;
      first_q <= 1'b0;
      idx_q   <= first_q ? (start_off_i & last_idx) : '0;
    end else if (fire) begin
      if (line_end) begin
        full_q  <= 1'b0;
        first_q <= 1'b1;
        idx_q   <= '0;
        cnt_q   <= '0;
      end else if (word_end) begin
        full_q <= 1'b0;
        idx_q  <= '0;
        cnt_q  <= cnt_inc;
      end else begin
        idx_q <= idx_q + 1'b1;
        cnt_q <= cnt_inc;
      end
    end
  end

  assign hold_valid_o = full_q;
  assign word_o       = word_q;
  assign idx_o        = idx_q;

  AST_ONE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !word_ready_o); // R6
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (idx_q <= last_idx)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_len_i != '0) |-> (cnt_q < line_len_i)); // R7
endmodule

// File: rtl/src_pixel_aligner.sv
module src_pixel_aligner
  import spa_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LINE_W = 12,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        depth_i,
  input  logic [LINE_W-1:0] line_len_i,
  input  logic [IDX_W-1:0]  start_off_i,
  input  logic [WORD_W-1:0] fg_color_i,
  input  logic [WORD_W-1:0] bg_color_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_data_i,
  output logic              word_ready_o,
  output logic              pix_valid_o,
  output logic [WORD_W-1:0] pix_data_o,
  input  logic              pix_ready_i
);
  src_mode_e         mode;
  pix_depth_e        depth;
  logic              hold_valid, mono_bit;
  logic [WORD_W-1:0] word, lane_pix;
  logic [IDX_W-1:0]  idx;

  assign mode  = src_mode_e'(mode_i);
  assign depth = pix_depth_e'(depth_i);

  spa_seq #(.WORD_W(WORD_W), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .depth_i      (depth),
    .line_len_i   (line_len_i),
    .start_off_i  (start_off_i),
    .word_valid_i (word_valid_i),
    .word_data_i  (word_data_i),
    .pix_ready_i  (pix_ready_i),
    .word_ready_o (word_ready_o),
    .hold_valid_o (hold_valid),
    .word_o       (word),
    .idx_o        (idx)
  );

  spa_lane_sel #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_lane (
    .word_i     (word),
    .idx_i      (idx),
    .depth_i    (depth),
    .pix_o      (lane_pix),
    .mono_bit_o (mono_bit)
  );

  always_comb begin
    case (mode)
      SM_VECTOR: pix_data_o = fg_color_i;
      SM_MONO:   pix_data_o = mono_bit ? fg_color_i : bg_color_i;
      default:   pix_data_o = lane_pix;
    endcase
  end
  assign pix_valid_o = (mode == SM_VECTOR) || hold_valid;

  AST_VECTOR_FG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SM_VECTOR) |-> (!word_ready_o && pix_valid_o && pix_data_o == fg_color_i)); // R5
  AST_MONO_TWO_COLORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == SM_MONO && pix_valid_o) |-> (pix_data_o == fg_color_i || pix_data_o == bg_color_i)); // R4
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_o && !pix_ready_i && mode != SM_VECTOR) |=> (pix_valid_o && $stable(pix_data_o))); // R9
endmodule

// File: tb/src_pixel_aligner_bench.sv
module src_pixel_aligner_bench;
  localparam int WORD_W = 32;
  localparam int LINE_W = 12;
  localparam int IDX_W  = $clog2(WORD_W);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = 2'd0, depth = 2'd0;
  logic [LINE_W-1:0] line_len = '0;
  logic [IDX_W-1:0]  start_off = '0;
  logic [WORD_W-1:0] fg = 32'hA5A5_0F0F, bg = 32'h1234_5678;
  logic              word_valid = 1'b0, pix_ready = 1'b0;
  logic [WORD_W-1:0] word_data = '0;
  logic              word_ready, pix_valid;
  logic [WORD_W-1:0] pix_data;

  int checks = 0, fails = 0, cyc = 0, total = 0;
  logic [31:0] wq[$];
  logic [31:0] eq[$];

  always #10 clk = ~clk;

  src_pixel_aligner #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_src_pixel_aligner (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .depth_i(depth),
    .line_len_i(line_len), .start_off_i(start_off),
    .fg_color_i(fg), .bg_color_i(bg),
    .word_valid_i(word_valid), .word_data_i(word_data), .word_ready_o(word_ready),
    .pix_valid_o(pix_valid), .pix_data_o(pix_data), .pix_ready_i(pix_ready)
  );

  always @(posedge clk) begin
    total++;
    if (total > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", total);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int ppw_of(input int m, input int d);
    if (m == 1) return 32;
    if (d == 0) return 4;
    if (d == 1) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] pix_of(input logic [31:0] w, input int k, input int m, input int d);
    if (m == 1) return w[(k & ~7) + 7 - (k & 7)] ? fg : bg;
    if (d == 0) return {24'h0, w[k*8 +: 8]};
    if (d == 1) return {16'h0, w[k*16 +: 16]};
    return w;
  endfunction

  task automatic run_line(input int m, input int d, input int len, input int off, input string req);
    int ppw, offm, nw, guard;
    logic [31:0] words[$];
    ppw  = ppw_of(m, d);
    offm = off % ppw;
    nw   = (offm + len + ppw - 1) / ppw;
    @(negedge clk);
    mode = 2'(m); depth = 2'(d); line_len = LINE_W'(len); start_off = IDX_W'(off);
    for (int i = 0; i < nw; i++) begin
      logic [31:0] w;
      w = $urandom;
      words.push_back(w);
      wq.push_back(w);
    end
    for (int k = offm; k < offm + len; k++) eq.push_back(pix_of(words[k / ppw], k % ppw, m, d));
    guard = 0;
    while ((wq.size() > 0 || eq.size() > 0) && guard < 2000) begin
      @(negedge clk);
      cyc++; guard++;
      word_valid = (wq.size() > 0);
      word_data  = (wq.size() > 0) ? wq[0] : 32'h0;
      pix_ready  = (cyc % 3) != 1;
      #1;
      if (word_valid && word_ready) void'(wq.pop_front());
      if (pix_valid && pix_ready) begin
        if (eq.size() == 0) chk(1'b0, req, pix_data, 32'h0);
        else begin
          logic [31:0] e;
          e = eq.pop_front();
          chk(pix_data === e, req, pix_data, e);
        end
      end
    end
    chk(guard < 2000, "R6 line drained", 32'(guard), 32'd2000);
    word_valid = 1'b0;
    pix_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!pix_valid, "R7 no extra pixel", 32'(pix_valid), 32'd0);
    end
    chk(word_ready, "R6 ready after line", 32'(word_ready), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!pix_valid, "R1 valid low", 32'(pix_valid), 32'd0);
    chk(word_ready, "R1 ready high", 32'(word_ready), 32'd1);
    rst_n = 1'b1;

    run_line(0, 0, 10, 1, "R2 8bpp offset1");
    run_line(0, 0, 10, 3, "R8 8bpp offset3");
    run_line(0, 0, 2, 0, "R7 8bpp short line");
    run_line(0, 1, 5, 1, "R3 16bpp");
    run_line(0, 2, 3, 0, "R3 32bpp");
    run_line(0, 3, 2, 5, "R3 32bpp alt code");
    run_line(1, 0, 40, 3, "R4 mono span");
    run_line(1, 2, 5, 2, "R7 mono short");
    run_line(1, 0, 64, 0, "R4 mono two words");

    // vector mode: input offered but must be ignored
    @(negedge clk);
    mode = 2'd2; word_valid = 1'b1; word_data = 32'hDEAD_BEEF; pix_ready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!word_ready, "R5 vector not ready", 32'(word_ready), 32'd0);
      chk(pix_valid && pix_data === fg, "R5 vector fg", pix_data, fg);
      pix_ready = 1'b1;
    end
    word_valid = 1'b0;
    run_line(0, 0, 4, 0, "R5 after vector");
    run_line(0, 1, 3, 0, "R9 16bpp backpressure");

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule